// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Controller

This block keeps the tag and valid state of a direct-mapped cache and answers a stream of read lookups. Each request carries a 32-bit word address. The controller drops the word-in-block bits to form a block address, chooses an entry with one of two index functions, and decides hit or miss. On a miss it installs the new block in that entry. It then returns the hit flag after a modelled access delay. The block holds no data. It is meant for measuring miss rates and the average access time of different cache geometries against a reference stream.

Two counters record the number of hits and the number of misses since reset. A mode pin chooses plain modulo indexing or an XOR fold of the upper block-address bits. Changing the mode empties the cache.

Requests and responses each use a valid/ready handshake:
- A request is taken on a clock edge when `req_valid_i` and `req_ready_o` are both high.
- Only one request is in flight at a time, so `req_ready_o` stays low from acceptance until the response handshake completes.
- A response is presented with `rsp_valid_o` and held, with its hit flag unchanged, until `rsp_ready_i` is high on a clock edge.

Top module: `dm_tag_ctrl`

## Requirements
- R1: After reset no entry is valid, `req_ready_o` is high, `rsp_valid_o` is low and both counters read zero. The first access to any entry is therefore a miss.
- R2: The block address is the word address shifted right by log2(WORDS_PER_BLK). All words of one block share an entry. With two-word blocks, word 3 misses and a following word 2 hits.
- R3: When `idx_mode_i` is 0, the entry index is the block address modulo NUM_BLOCKS. Two blocks that map to the same entry evict each other.
- R4: When `idx_mode_i` is 1, the index is the top log2(NUM_BLOCKS) bits of the block address XOR the next log2(NUM_BLOCKS) bits below them. A hit requires the whole stored block address to match, so two blocks that share an index never hit for each other.
- R5: On a miss the indexed entry is overwritten with the new block and marked valid. A repeat of that address then hits.
- R6: `rsp_valid_o` rises exactly HIT_LAT clock edges after acceptance for a hit. For a miss it rises exactly HIT_LAT+MISS_STALL edges after acceptance.
- R7: `req_ready_o` is low from the edge that accepts a request until the edge that completes its response handshake.
- R8: While `rsp_valid_o` is high and `rsp_ready_i` is low, `rsp_valid_o` stays high and `rsp_hit_o` does not change.
- R9: A change of `idx_mode_i` invalidates every entry. `req_ready_o` is low in the one cycle in which the change is taken.
- R10: Each accepted request adds one to the hit counter if it hits, or to the miss counter if it misses. Both counters saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_mode_i | input | 1 | Index function: 0 modulo, 1 XOR fold |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_addr_i | input | ADDR_W (32) | Word address of the read |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_hit_o | output | 1 | 1 if the request hit |
| hit_count_o | output | CNT_W (32) | Saturating number of hits |
| miss_count_o | output | CNT_W (32) | Saturating number of misses |

## Verification
The lookup is tried with four kinds of input.

- **Reference stream.** A fixed stream of small word addresses is sent to two configurations, 16 one-word blocks and 8 two-word blocks. This separates the word-dropping shift from the index slice, because only the two-word configuration hits inside a block.
- **Directed conflict pairs.** In modulo mode, address pairs that share an entry show eviction. In XOR mode, pairs whose upper bits fold to the same index expose any false hit from a truncated tag.
- **Random stream with mode switches.** Addresses drawn from a small pool, mixed with high-bit addresses and occasional mode switches, are checked against a bench model. This covers flushing, hit latency against miss latency, and counter saturation in a narrow-counter instance.
- **Held-back response.** One response is held back to show that it stays stable under back-pressure.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic {
    IDX_MOD = 1'b0,
    IDX_XOR = 1'b1
  } idx_mode_e;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_WAIT = 2'd1,
    T_RESP = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/dmc_index.sv
module dmc_index
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 0,
  parameter int IDX_W  = 4,
  parameter int BA_W   = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  idx_mode_e         mode_i,
  output logic [BA_W-1:0]   blk_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] idx_mod;
  logic [IDX_W-1:0] idx_xor;

  assign blk_o   = addr_i[ADDR_W-1:OFF_W];
  assign idx_mod = blk_o[IDX_W-1:0];

  generate
    if (BA_W >= 2 * IDX_W) begin : g_fold
      assign idx_xor = blk_o[BA_W-1 -: IDX_W] ^ blk_o[BA_W-1-IDX_W -: IDX_W];
    end else begin : g_nofold
      assign idx_xor = idx_mod;
    end
  endgenerate

  assign idx_o = (mode_i == IDX_XOR) ? idx_xor : idx_mod;
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int NUM_BLOCKS = 16,
  parameter int IDX_W      = $clog2(NUM_BLOCKS),
  parameter int BA_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BA_W-1:0]  blk_i,
  input  logic             fill_i,
  input  logic             flush_i,
  output logic             hit_o
);
  logic [NUM_BLOCKS-1:0] valid_q;
  logic [BA_W-1:0]       tag_q [NUM_BLOCKS];

  assign hit_o = valid_q[idx_i] && (tag_q[idx_i] == blk_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_i && !flush_i) begin
      tag_q[idx_i] <= blk_i;
    end
  end

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));

  // R5
  fill_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !flush_i) |=> (valid_q[$past(idx_i)] && (tag_q[$past(idx_i)] == $past(blk_i))));
endmodule

// File: rtl/dmc_lat_timer.sv
module dmc_lat_timer
  import dmc_pkg::*;
#(
  parameter int HIT_LAT    = 2,
  parameter int MISS_STALL = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic miss_i,
  input  logic rsp_ready_i,
  output logic busy_o,
  output logic rsp_valid_o
);
  localparam int              TOTAL   = HIT_LAT + MISS_STALL;
  localparam int              CW      = $clog2(TOTAL + 1);
  localparam logic [CW-1:0]   LD_HIT  = CW'(HIT_LAT - 1);
  localparam logic [CW-1:0]   LD_MISS = CW'(TOTAL - 1);

  tmr_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        T_IDLE: if (start_i) begin
          state_q <= T_WAIT;
          cnt_q   <= miss_i ? LD_MISS : LD_HIT;
        end
        T_WAIT: if (cnt_q == '0) state_q <= T_RESP;
                else cnt_q <= cnt_q - 1'b1;
        T_RESP: if (rsp_ready_i) state_q <= T_IDLE;
        default: state_q <= T_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != T_IDLE);
  assign rsp_valid_o = (state_q == T_RESP);

  // checker state: edges elapsed since acceptance and the delay expected
  logic [CW-1:0] el_q;
  logic [CW-1:0] exp_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el_q  <= '0;
      exp_q <= '0;
    end else if (start_i && !busy_o) begin
      el_q  <= '0;
      exp_q <= miss_i ? CW'(TOTAL) : CW'(HIT_LAT);
    end else if (state_q == T_WAIT) begin
      el_q <= el_q + 1'b1;
    end
  end

  // R6
  resp_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid_o) |-> (el_q == exp_q));
endmodule

// File: rtl/dmc_sat_cnt.sv
module dmc_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_o <= '0;
    else if (inc_i && (cnt_o != '1)) cnt_o <= cnt_o + 1'b1;
  end

  // R10
  cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && (cnt_o == '1)) |=> (cnt_o == '1));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && (cnt_o != '1)) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/dm_tag_ctrl.sv
module dm_tag_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int NUM_BLOCKS    = 16,
  parameter int WORDS_PER_BLK = 1,
  parameter int HIT_LAT       = 2,
  parameter int MISS_STALL    = 25,
  parameter int CNT_W         = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_hit_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int OFF_W = $clog2(WORDS_PER_BLK);
  localparam int IDX_W = $clog2(NUM_BLOCKS);
  localparam int BA_W  = ADDR_W - OFF_W;

  idx_mode_e        mode_now;
  idx_mode_e        mode_q;
  logic             flush;
  logic             busy;
  logic             accept;
  logic             lookup_hit;
  logic             hit_q;
  logic [BA_W-1:0]  blk;
  logic [IDX_W-1:0] idx;

  assign mode_now    = idx_mode_e'(idx_mode_i);
  assign flush       = (mode_now != mode_q);
  assign req_ready_o = !busy && !flush;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_now;
    else        mode_q <= mode_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hit_q <= 1'b0;
    else if (accept) hit_q <= lookup_hit;
  end
  assign rsp_hit_o = hit_q;

  dmc_index #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .BA_W(BA_W)
  ) u_index (
    .addr_i(req_addr_i), .mode_i(mode_now), .blk_o(blk), .idx_o(idx)
  );

  dmc_tag_store #(
    .NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .BA_W(BA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .idx_i(idx), .blk_i(blk),
    .fill_i(accept && !lookup_hit), .flush_i(flush), .hit_o(lookup_hit)
  );

  dmc_lat_timer #(
    .HIT_LAT(HIT_LAT), .MISS_STALL(MISS_STALL)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .miss_i(!lookup_hit),
    .rsp_ready_i(rsp_ready_i), .busy_o(busy), .rsp_valid_o(rsp_valid_o)
  );

  dmc_sat_cnt #(.W(CNT_W)) u_hits (
    .clk(clk), .rst_n(rst_n), .inc_i(accept && lookup_hit), .cnt_o(hit_count_o)
  );

  dmc_sat_cnt #(.W(CNT_W)) u_misses (
    .clk(clk), .rst_n(rst_n), .inc_i(accept && !lookup_hit), .cnt_o(miss_count_o)
  );

  // R7
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready_o);

  // R7
  no_ready_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_hit_o)));
endmodule

// File: tb/dm_tag_ctrl_tb.sv
`timescale 1ns/1ps
module dm_tag_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        rv = 1'b0;
  logic [31:0] ra = '0;
  logic        sr1 = 1'b1, sr2 = 1'b1;
  logic        rdy1, rdy2, sv1, sv2, sh1, sh2;
  logic [31:0] hc1, mc1;
  logic [4:0]  hc2, mc2;

  int nt = 0;
  int nf = 0;

  // model state
  logic [15:0] mv1;
  logic [31:0] mt1 [16];
  logic [7:0]  mv2;
  logic [30:0] mt2 [8];
  int eh1, em1, eh2, em2;

  always #2.5 clk = ~clk;

  // 16 one-word blocks, hit 2, stall 25
  dm_tag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .idx_mode_i(mode), .req_valid_i(rv),
    .req_ready_o(rdy1), .req_addr_i(ra), .rsp_valid_o(sv1), .rsp_ready_i(sr1),
    .rsp_hit_o(sh1), .hit_count_o(hc1), .miss_count_o(mc1)
  );

  // 8 two-word blocks, hit 3, stall 25, narrow counters
  dm_tag_ctrl #(
    .NUM_BLOCKS(8), .WORDS_PER_BLK(2), .HIT_LAT(3), .MISS_STALL(25), .CNT_W(5)
  ) u_dut2 (
    .clk(clk), .rst_n(rst_n), .idx_mode_i(mode), .req_valid_i(rv),
    .req_ready_o(rdy2), .req_addr_i(ra), .rsp_valid_o(sv2), .rsp_ready_i(sr2),
    .rsp_hit_o(sh2), .hit_count_o(hc2), .miss_count_o(mc2)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int midx(input logic [31:0] a, input int off, input int iw, input logic m);
    logic [31:0] b;
    logic [31:0] mask;
    int bw;
    b = a >> off;
    bw = 32 - off;
    mask = (32'd1 << iw) - 1;
    if (!m) return int'(b & mask);
    return int'(((b >> (bw - iw)) ^ (b >> (bw - 2 * iw))) & mask);
  endfunction

  task automatic do_req(input logic [31:0] a, input string rq, input bit bp);
    int i1, i2, l1, l2;
    bit e1, e2, g1, g2;
    logic [31:0] b2;
    i1 = midx(a, 0, 4, mode);
    e1 = mv1[i1] && (mt1[i1] == a);
    mv1[i1] = 1'b1; mt1[i1] = a;
    b2 = a >> 1;
    i2 = midx(a, 1, 3, mode);
    e2 = mv2[i2] && (mt2[i2] == b2[30:0]);
    mv2[i2] = 1'b1; mt2[i2] = b2[30:0];
    if (e1) eh1++; else em1++;
    if (e2) begin if (eh2 < 31) eh2++; end else begin if (em2 < 31) em2++; end

    @(negedge clk);
    chk(rdy1 && rdy2, "R7 ready when idle", {rdy1, rdy2}, 3);
    rv = 1'b1; ra = a; sr1 = !bp; sr2 = !bp;
    @(posedge clk);
    @(negedge clk);
    rv = 1'b0;
    chk(!rdy1 && !rdy2, "R7 ready low after accept", {rdy1, rdy2}, 0);
    g1 = 0; g2 = 0; l1 = 0; l2 = 0;
    for (int k = 1; k < 100 && !(g1 && g2); k++) begin
      @(posedge clk);
      @(negedge clk);
      if (!g1 && sv1) begin
        g1 = 1; l1 = k;
        chk(sh1 == e1, {rq, " hit flag dut1"}, sh1, e1);
      end
      if (!g2 && sv2) begin
        g2 = 1; l2 = k;
        chk(sh2 == e2, {rq, " hit flag dut2"}, sh2, e2);
      end
    end
    // R6
    chk(l1 == (e1 ? 2 : 27), "R6 latency dut1", l1, e1 ? 2 : 27);
    chk(l2 == (e2 ? 3 : 28), "R6 latency dut2", l2, e2 ? 3 : 28);
    if (bp) begin
      for (int j = 0; j < 4; j++) begin
        @(posedge clk);
        @(negedge clk);
        // R8
        chk(sv1 && sv2 && sh1 == e1 && sh2 == e2, "R8 response held",
            {sv1, sv2, sh1, sh2}, {2'b11, e1, e2});
        chk(!rdy1 && !rdy2, "R7 ready low while response held", {rdy1, rdy2}, 0);
      end
      sr1 = 1'b1; sr2 = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    // R10
    chk(hc1 == 32'(eh1) && mc1 == 32'(em1), "R10 counts dut1", {hc1, mc1}, {32'(eh1), 32'(em1)});
    chk(hc2 == 5'(eh2) && mc2 == 5'(em2), "R10 counts dut2 saturating", {hc2, mc2}, {5'(eh2), 5'(em2)});
    chk(rdy1 && rdy2, "R7 ready after response", {rdy1, rdy2}, 3);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode = m;
    #1;
    // R9
    chk(!rdy1 && !rdy2, "R9 ready low in flush cycle", {rdy1, rdy2}, 0);
    @(posedge clk);
    @(negedge clk);
    chk(rdy1 && rdy2, "R9 ready back after flush", {rdy1, rdy2}, 3);
    mv1 = '0; mv2 = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    nf++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    logic [31:0] a;
    int unsigned s;
    s = $urandom(32'd2024);
    mv1 = '0; mv2 = '0;
    eh1 = 0; em1 = 0; eh2 = 0; em2 = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(rdy1 && rdy2 && !sv1 && !sv2, "R1 reset handshake state", {rdy1, rdy2, sv1, sv2}, 4'b1100);
    chk(hc1 == 0 && mc1 == 0 && hc2 == 0 && mc2 == 0, "R1 counters zero", hc1 + mc1 + hc2 + mc2, 0);

    // reference stream, modulo mode: dut2 hits on words 2, 190, 181 (R2, R3)
    do_req(32'd3,   "R1 first access", 0);
    do_req(32'd180, "R3", 0);
    do_req(32'd43,  "R3", 0);
    do_req(32'd2,   "R2 shared block", 0);
    do_req(32'd191, "R3", 0);
    do_req(32'd88,  "R3", 0);
    do_req(32'd190, "R2 shared block", 0);
    do_req(32'd14,  "R3 eviction", 0);
    do_req(32'd181, "R2 shared block", 0);
    do_req(32'd44,  "R3", 0);
    do_req(32'd186, "R3", 0);
    do_req(32'd253, "R3", 0);
    do_req(32'd253, "R5 refill hit", 0);
    // modulo conflict
    do_req(32'd0,  "R3 conflict", 0);
    do_req(32'd16, "R3 conflict", 0);
    do_req(32'd0,  "R3 conflict", 0);
    // back-pressure
    do_req(32'd0,  "R8 held hit", 1);
    do_req(32'd64, "R8 held miss", 1);

    // switch to XOR folding, entries must be gone
    set_mode(1'b1);
    do_req(32'd0, "R9 miss after flush", 0);
    do_req(32'h1100_0000, "R4 same fold index no false hit", 0);
    do_req(32'd0, "R4 evicted by fold partner", 0);
    do_req(32'h1000_0005, "R4", 0);
    do_req(32'h1000_0005, "R5 hit in XOR mode", 0);
    set_mode(1'b0);
    do_req(32'h1000_0005, "R9 miss after flush", 0);

    // random stream
    for (int n = 0; n < 110; n++) begin
      if ($urandom_range(0, 19) == 0) set_mode(~mode);
      if ($urandom_range(0, 3) == 3)
        a = {4'($urandom_range(0, 15)), 4'($urandom_range(0, 3)), 24'($urandom_range(0, 7))};
      else
        a = 32'($urandom_range(0, 47));
      do_req(a, "R5 random stream", 0);
    end

    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule